// File: doc/BRIEF.md
# I2C Expander Power-Up Configurator

This block runs by itself once after reset. It contains a write-only I2C master and a two-step sequencer. Together they set one pin of an I/O expander as an output and drive that pin low. The sequencer first writes 0xFB to register 0x03, the direction register, so that pin 2 becomes an output. It then writes 0xFB to register 0x01, the output register, so that pin 2 is driven low. After that it parks, and it issues no further bus traffic until the next reset.

The sequencer and the master talk over a request/busy handshake. The sequencer raises a request together with a register address and a data byte, and holds all three until busy rises. The master latches them, raises busy and runs the frame. The sequencer drops the request the cycle after busy rises, so the request is already low when busy falls at the end of the frame.

The bus pins are open drain and are modelled as pull-low enables: a 1 on an enable pulls the line low, and a 0 releases it. Each SCL period is split into four equal quarters, with SCL low in the first two and high in the last two. The quarter length comes from the system clock and the SCL rate given as parameters.

Top module: `ioexp_cfg_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both line enables are 0 (lines released), cfg_done is 0 and cfg_err is 0.
- R2: SDA changes only while SCL is low. The two exceptions are START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high), and each transfer contains exactly one of each.
- R3: cmd_req stays high, with its address and data stable, from the cycle it rises until busy rises.
- R4: cmd_busy rises exactly one cycle after cmd_req rises. cmd_req falls exactly one cycle after cmd_busy rises, and cmd_req is low when cmd_busy falls.
- R5: A frame is START, then the 7-bit device address (default 0x20) MSB first with write bit 0 (byte 0x40), ACK, register byte, ACK, data byte, ACK, then STOP. All bytes are sent MSB first, and ACK means the target holds SDA low.
- R6: The first transfer writes data 0xFB to register 0x03.
- R7: The second transfer writes data 0xFB to register 0x01. After it, cfg_done goes to 1 and stays at 1, no further transfer starts, and both lines stay released.
- R8: A NACK (SDA high) in any of the three ACK slots ends the transfer with STOP right after that slot, drops busy, and sets cfg_err. cfg_err stays set until reset. The sequencer then parks (cfg_done=1) and issues no further write.
- R9: With QTR = CLK_HZ/(4*SCL_HZ), the SCL period is 4*QTR clocks and SCL is high for 2*QTR of them. Busy stays high for (2+9*k)*4*QTR clocks, where k is the number of bytes sent (3 for a full frame).
- R10: A reset in the middle of a transfer aborts it. Both writes then run again from the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cmd_req | output | 1 | Write request from the sequencer to the master |
| cmd_busy | output | 1 | Master is running a write frame |
| cfg_done | output | 1 | Sequencer has parked |
| cfg_err | output | 1 | Sticky flag: a target NACK was seen |

## Verification
Busy is due one clock after the request rises, and the request falls one clock after busy rises. Busy then lasts exactly (2+9*k)*4*QTR clocks. Both line enables are registered, so every line edge follows its phase boundary by one cycle, and SCL high time and period are measured as exact clock counts. The ACK level is sampled at the end of the first high quarter of the ninth SCL clock. The bench target model therefore drives ACK from the preceding SCL fall. All port samples are taken on the falling clock edge, so no check races the edge at which a result changes.

// File: rtl/ioexp_cfg_seq.sv
module ioexp_cfg_seq #(
  parameter int          CLK_HZ   = 250_000_000,
  parameter int          SCL_HZ   = 400_000,
  parameter logic [6:0]  DEV_ADDR = 7'h20,
  parameter logic [7:0]  REG_A    = 8'h03,
  parameter logic [7:0]  DATA_A   = 8'hFB,
  parameter logic [7:0]  REG_B    = 8'h01,
  parameter logic [7:0]  DATA_B   = 8'hFB
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic cmd_req,
  output logic cmd_busy,
  output logic cfg_done,
  output logic cfg_err
);

  localparam int QRAW = CLK_HZ / (4 * SCL_HZ);
  localparam int QTR  = (QRAW < 2) ? 2 : QRAW;
  localparam int QW   = $clog2(QTR);

  typedef enum logic [2:0] {Q_REQ1, Q_RUN1, Q_REQ2, Q_RUN2, Q_PARK} seq_t;
  typedef enum logic [2:0] {M_IDLE, M_START, M_BIT, M_ACK, M_STOP} mst_t;

  seq_t        sq;
  mst_t        ms;
  logic [7:0]  cmd_reg, cmd_dat;
  logic [1:0]  ph;
  logic [QW-1:0] qc;
  logic [23:0] sh;
  logic [2:0]  bn;
  logic [1:0]  by;
  logic        ack_bad;
  logic        scl_lo, sda_lo;
  logic        tick;

  assign tick     = (ms != M_IDLE) && (qc == QW'(QTR - 1));
  assign cfg_done = (sq == Q_PARK);

  // sequencer: two fixed writes, then park
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq      <= Q_REQ1;
      cmd_req <= 1'b0;
      cmd_reg <= 8'h00;
      cmd_dat <= 8'h00;
    end else begin
      case (sq)
        Q_REQ1, Q_REQ2: begin
          if (!cmd_req && !cmd_busy) begin
            cmd_req <= 1'b1;
            cmd_reg <= (sq == Q_REQ1) ? REG_A  : REG_B;
            cmd_dat <= (sq == Q_REQ1) ? DATA_A : DATA_B;
          end else if (cmd_req && cmd_busy) begin
            cmd_req <= 1'b0;
            sq      <= (sq == Q_REQ1) ? Q_RUN1 : Q_RUN2;
          end
        end
        Q_RUN1: if (!cmd_busy) sq <= cfg_err ? Q_PARK : Q_REQ2;
        Q_RUN2: if (!cmd_busy) sq <= Q_PARK;
        default: sq <= Q_PARK;
      endcase
    end
  end

  // line levels per state and quarter; SDA data moves in quarter 1
  always_comb begin
    scl_lo = 1'b0;
    sda_lo = 1'b0;
    case (ms)
      M_START: sda_lo = ph[1];
      M_BIT: begin
        scl_lo = !ph[1];
        sda_lo = (ph == 2'd0) ? sda_oe : !sh[23];
      end
      M_ACK: begin
        scl_lo = !ph[1];
        sda_lo = (ph == 2'd0) ? sda_oe : 1'b0;
      end
      M_STOP: begin
        scl_lo = !ph[1];
        sda_lo = (ph == 2'd0) ? sda_oe : (ph != 2'd3);
      end
      default: ;
    endcase
  end

  // byte-write master
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms       <= M_IDLE;
      ph       <= 2'd0;
      qc       <= '0;
      sh       <= 24'h0;
      bn       <= 3'd0;
      by       <= 2'd0;
      ack_bad  <= 1'b0;
      cmd_busy <= 1'b0;
      cfg_err  <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      scl_oe <= scl_lo;
      sda_oe <= sda_lo;
      if (ms == M_IDLE) begin
        if (cmd_req) begin
          sh       <= {DEV_ADDR, 1'b0, cmd_reg, cmd_dat};
          cmd_busy <= 1'b1;
          ms       <= M_START;
          ph       <= 2'd0;
          qc       <= '0;
        end
      end else begin
        qc <= tick ? '0 : qc + 1'b1;
        if (tick) begin
          ph <= ph + 2'd1;
          if (ms == M_ACK && ph == 2'd2) ack_bad <= sda_in;
          if (ph == 2'd3) begin
            case (ms)
              M_START: begin
                ms <= M_BIT;
                bn <= 3'd7;
                by <= 2'd0;
              end
              M_BIT: begin
                sh <= {sh[22:0], 1'b0};
                if (bn == 3'd0) ms <= M_ACK;
                else bn <= bn - 3'd1;
              end
              M_ACK: begin
                if (ack_bad) begin
                  cfg_err <= 1'b1;
                  ms      <= M_STOP;
                end else if (by == 2'd2) begin
                  ms <= M_STOP;
                end else begin
                  by <= by + 2'd1;
                  bn <= 3'd7;
                  ms <= M_BIT;
                end
              end
              default: begin
                ms       <= M_IDLE;
                cmd_busy <= 1'b0;
              end
            endcase
          end
        end
      end
    end
  end

  a_r2_sda_steady_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && !$stable(sda_oe)) |-> (ms == M_START || ms == M_STOP));

  a_r3_req_held_until_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_busy) |=> (cmd_req && $stable(cmd_reg) && $stable(cmd_dat)));

  a_r4_req_drops_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy) |=> !cmd_req);

  a_r4_req_low_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_busy) |-> !cmd_req);

  a_r7_park_is_final: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> (cfg_done && !cmd_req && !cmd_busy));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

// File: tb/ioexp_cfg_seq_tb.sv
`timescale 1ns/1ps
module ioexp_cfg_seq_tb_top;

  localparam int CLK_HZ = 250_000_000;
  localparam int SCL_HZ = 10_000_000;
  localparam int QTR    = CLK_HZ / (4 * SCL_HZ);
  localparam int PER    = 4 * QTR;

  // {nack_txn[1:0], nack_slot[1:0], exp_txn[1:0], exp_err}
  localparam logic [6:0] VEC [6] = '{
    {2'd0, 2'd0, 2'd2, 1'b0},
    {2'd1, 2'd1, 2'd1, 1'b1},
    {2'd1, 2'd2, 2'd1, 1'b1},
    {2'd1, 2'd3, 2'd1, 1'b1},
    {2'd2, 2'd1, 2'd2, 1'b1},
    {2'd2, 2'd3, 2'd2, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_oe, sda_oe, cmd_req, cmd_busy, cfg_done, cfg_err;
  logic ack_drv;
  logic sda_in_w;

  always #2 clk = ~clk;

  assign sda_in_w = !(sda_oe || ack_drv);

  ioexp_cfg_seq #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cmd_req(cmd_req), .cmd_busy(cmd_busy),
    .cfg_done(cfg_done), .cfg_err(cfg_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // target model
  int nk_txn = 0, nk_slot = 0;
  int txn_cnt, starts, stops, cur, bitc, byc;
  int t_rise, per_meas, hi_meas;
  bit in_t, acking, rose_seen, prev_scl, prev_msda;
  logic [7:0] shr;
  logic [7:0] cap [4][3];

  always @(negedge clk) begin
    bit scl_l, msda;
    scl_l = !scl_oe;
    msda  = !sda_oe;
    if (!rst_n) begin
      txn_cnt = 0; starts = 0; stops = 0; cur = 0; bitc = 0; byc = 0;
      in_t = 0; acking = 0; rose_seen = 0; ack_drv = 1'b0;
      prev_scl = 1; prev_msda = 1; shr = 8'h00;
      per_meas = 0; hi_meas = 0; t_rise = 0;
    end else begin
      if (prev_scl && scl_l && prev_msda && !msda) begin
        starts++; cur = txn_cnt; txn_cnt++;
        bitc = 0; byc = 0; in_t = 1; acking = 0; rose_seen = 0;
      end else if (prev_scl && scl_l && !prev_msda && msda) begin
        stops++; in_t = 0; ack_drv = 1'b0;
      end else if (in_t && !prev_scl && scl_l) begin
        if (bitc < 8) begin
          shr = {shr[6:0], msda};
          bitc++;
          if (bitc >= 2) per_meas = cyc - t_rise;
        end
        t_rise = cyc;
        rose_seen = 1;
      end else if (in_t && prev_scl && !scl_l) begin
        if (rose_seen) hi_meas = cyc - t_rise;
        if (bitc == 8 && !acking) begin
          if (cur < 4 && byc < 3) cap[cur][byc] = shr;
          ack_drv = !((cur + 1 == nk_txn) && (byc + 1 == nk_slot));
          acking = 1;
          byc++;
        end else if (acking) begin
          ack_drv = 1'b0;
          acking = 0;
          bitc = 0;
        end
      end
      prev_scl = scl_l;
      prev_msda = msda;
    end
  end

  // handshake monitor (R3, R4, R9)
  bit p_req, p_busy;
  int t_rq, t_br, nb;
  int blen [4];

  always @(negedge clk) begin
    if (!rst_n) begin
      p_req = 0; p_busy = 0; nb = 0;
    end else begin
      if (cmd_req && !p_req) t_rq = cyc;
      if (cmd_busy && !p_busy) begin
        t_br = cyc;
        check(cyc - t_rq == 1, "R4 busy one cycle after request", cyc - t_rq, 1);
      end
      if (!cmd_req && p_req) begin
        check(cmd_busy && (cyc - t_br == 1), "R3 request held until busy then dropped",
              cyc - t_br, 1);
      end
      if (!cmd_busy && p_busy) begin
        check(!cmd_req, "R4 request low when busy falls", int'(cmd_req), 0);
        if (nb < 4) blen[nb] = cyc - t_br;
        nb++;
      end
      p_req = cmd_req;
      p_busy = cmd_busy;
    end
  end

  function automatic logic [7:0] exp_byte(input int t, input int b);
    if (b == 0) return 8'h40;
    if (b == 1) return (t == 0) ? 8'h03 : 8'h01;
    return 8'hFB;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk);
      if (cfg_done) break;
    end
    repeat (100) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!scl_oe && !sda_oe, "R1 lines released in reset", int'({scl_oe, sda_oe}), 0);
    check(!cfg_done && !cfg_err, "R1 flags clear in reset", int'({cfg_done, cfg_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scl_oe && !sda_oe && !cfg_done && !cfg_err, "R1 state after release",
          int'({scl_oe, sda_oe, cfg_done, cfg_err}), 0);
    wait_done();

    // table of NACK placements
    for (int v = 0; v < 6; v++) begin
      int nt, ns, et, ee;
      nt = int'(VEC[v][6:5]);
      ns = int'(VEC[v][4:3]);
      et = int'(VEC[v][2:1]);
      ee = int'(VEC[v][0]);
      nk_txn = nt;
      nk_slot = ns;
      do_reset();
      wait_done();
      check(cfg_done == 1'b1, "R7/R8 sequencer parked", int'(cfg_done), 1);
      check(int'(cfg_err) == ee, "R8 error flag", int'(cfg_err), ee);
      check(txn_cnt == et, "R7/R8 transfer count", txn_cnt, et);
      check(starts == et && stops == et, "R2 one START and one STOP per transfer",
            stops, et);
      check(!scl_oe && !sda_oe, "R7 lines released when parked", int'({scl_oe, sda_oe}), 0);
      for (int t = 0; t < et; t++) begin
        int nbytes;
        nbytes = (t + 1 == nt) ? ns : 3;
        for (int b = 0; b < nbytes; b++)
          check(cap[t][b] == exp_byte(t, b), (t == 0) ? "R5/R6 byte of first write"
                : "R5/R7 byte of second write", int'(cap[t][b]), int'(exp_byte(t, b)));
        check(blen[t] == (2 + 9 * nbytes) * PER, "R9/R8 busy width", blen[t],
              (2 + 9 * nbytes) * PER);
      end
    end

    // R9: SCL timing
    nk_txn = 0;
    nk_slot = 0;
    do_reset();
    wait_done();
    check(per_meas == PER, "R9 SCL period", per_meas, PER);
    check(hi_meas == 2 * QTR, "R9 SCL high time", hi_meas, 2 * QTR);

    // R7: no activity after parking
    begin
      int tc;
      tc = txn_cnt;
      repeat (400) @(posedge clk);
      @(negedge clk);
      check(txn_cnt == tc && !cmd_req && !scl_oe && !sda_oe, "R7 quiet after park",
            txn_cnt, tc);
      check(cfg_done && !cfg_err, "R7 flags after clean run", int'({cfg_done, cfg_err}), 2);
    end

    // R10: reset mid-transfer
    do_reset();
    repeat (300) @(posedge clk);
    @(negedge clk);
    check(cmd_busy == 1'b1, "R10 transfer in progress before reset", int'(cmd_busy), 1);
    do_reset();
    wait_done();
    check(txn_cnt == 2 && !cfg_err, "R10 both writes rerun", txn_cnt, 2);
    check(cap[0][1] == 8'h03 && cap[1][1] == 8'h01, "R10 order restarts at first write",
          int'(cap[0][1]), 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule